// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port sitting on a small byte-wide register bus. Each pin has a direction bit and an output data bit. The direction bits drive the pin output enables directly. The output data bits drive the pin outputs.

The data register is reached through an address window rather than a single location. Byte-address bits [9:2] form a per-pin mask. A write changes only the output bits whose mask bit is set. A read returns pin values in the masked positions and zeros elsewhere. Software can therefore set or clear one pin with a single write to address `1 << (n+2)`, without first reading the register. A data write is accepted only for pins configured as outputs. Software has to turn a pin into an output first and then write its value.

Pin inputs pass through a two-stage synchroniser before they reach the read path. A read of an output pin returns the value being driven. A read of an input pin returns the synchronised level.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset every direction bit is 0 (input), every output data bit is 0, `pin_oe` and `pin_out` are 0, and the direction register reads 0.
- R2: A write to byte address 0x400 loads the direction register (bit n = 1 makes pin n an output). Address 0x400 reads it back. `pin_oe` equals the direction register from the clock edge after the write.
- R3: A write to a word-aligned address below 0x400 updates output bit n only when address bit n+2 is set. All other bits keep their value.
- R4: A data write has no effect on the output bit of a pin whose direction bit is 0. After that pin is made an output, it drives its earlier value.
- R5: A read of a word-aligned address below 0x400 returns 0 in every bit n whose address bit n+2 is clear.
- R6: In a masked position, a read returns the output data bit for an output pin. For an input pin it returns the pin level sampled two clock edges earlier (two-stage synchroniser).
- R7: `pin_out` always shows the output data register, whatever the directions are.
- R8: Addresses that are neither word-aligned data addresses below 0x400 nor exactly 0x400 read as 0. Writes to them change nothing. This covers 0x404 and above and any address with bits [1:0] non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data to the pads |
| pin_oe | output | 8 | Output enables, 1 = drive |

## Verification
The masked write is driven by a table of mask and data pairs, each followed by a full read and a masked read. The masks are chosen to separate distinct behaviours:
- single low and high bits, which show bit-to-address alignment;
- complementary nibbles, which catch a mask that is inverted or reversed;
- an empty mask, which must change nothing;
- scattered masks.

Directed tests cover the following:
- a write to input pins, followed by turning them into outputs, shows that the write was dropped;
- a mixed-direction read shows, cycle by cycle, that the synchroniser delay is exactly two edges;
- writes and reads at 0x404, 0x500 and a misaligned address show that unmapped space is inert.

// File: rtl/masked_gpio_port.sv
module masked_gpio_port #(
  parameter int NPIN = 8,
  localparam int AW = NPIN + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  localparam logic [AW-1:0] DIR_ADDR = AW'(1) << (NPIN + 2);

  logic [NPIN-1:0] dir_q, dout_q, meta_q, sync_q;
  logic [NPIN-1:0] amask, wr_bits, level;
  logic            in_window, at_dir;

  assign amask     = bus_addr[NPIN+1:2];
  assign in_window = !bus_addr[AW-1] && (bus_addr[1:0] == 2'b00);
  assign at_dir    = (bus_addr == DIR_ADDR);
  assign wr_bits   = amask & dir_q;
  assign level     = (dir_q & dout_q) | (~dir_q & sync_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (bus_we && at_dir)
        dir_q <= bus_wdata;
      if (bus_we && in_window)
        dout_q <= (dout_q & ~wr_bits) | (bus_wdata & wr_bits);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_window)   bus_rdata = level & amask;
    else if (at_dir) bus_rdata = dir_q;
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  assert_oe_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DIR_ADDR) |=> (pin_oe == $past(bus_wdata)));

  assert_unmasked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[AW-1]) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[NPIN+1:2])) == '0));

  assert_input_pin_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  assert_read_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[AW-1] |-> ((bus_rdata & ~bus_addr[NPIN+1:2]) == '0));

  assert_unmapped_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1] && bus_addr != DIR_ADDR) |=>
      ($stable(pin_out) && $stable(pin_oe)));

  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1] && bus_addr != DIR_ADDR) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_masked_gpio_port.sv
module sim_masked_gpio_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  masked_gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #5 clk = ~clk;

  // {mask, wdata, expected output register after the write}; all pins outputs, start 0
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'hFF, 8'h01},
    {8'h80, 8'hFF, 8'h81},
    {8'hFF, 8'h5A, 8'h5A},
    {8'h0F, 8'hF0, 8'h50},
    {8'hF0, 8'h0F, 8'h00},
    {8'h00, 8'hFF, 8'h00},
    {8'h3C, 8'hA5, 8'h24},
    {8'hC3, 8'hFF, 8'hE7}
  };

  function automatic logic [10:0] maddr(input logic [7:0] m);
    return {1'b0, m, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    rd(11'h400, r); check("R1 dir read", r, 8'h00);

    wr(11'h400, 8'h0F);
    check("R2 oe", pin_oe, 8'h0F);
    rd(11'h400, r); check("R2 dir read", r, 8'h0F);
    wr(11'h400, 8'hFF);
    check("R2 oe all", pin_oe, 8'hFF);

    for (int i = 0; i < 8; i++) begin
      wr(maddr(VEC[i][23:16]), VEC[i][15:8]);
      check("R3 R7 pin_out", pin_out, VEC[i][7:0]);
      rd(maddr(8'hFF), r); check("R3 R6 full read", r, VEC[i][7:0]);
      rd(maddr(VEC[i][23:16]), r);
      check("R5 masked read", r, VEC[i][7:0] & VEC[i][23:16]);
    end

    wr(11'h400, 8'h0F);
    wr(maddr(8'hFF), 8'h00);
    check("R4 input bits held", pin_out, 8'hE0);
    wr(maddr(8'hF0), 8'h1F);
    check("R4 input write dropped", pin_out, 8'hE0);

    @(negedge clk) pin_in = 8'hA5;
    @(posedge clk); #1;
    rd(maddr(8'hFF), r); check("R6 one edge old", r, 8'h00);
    @(posedge clk); #1;
    rd(maddr(8'hFF), r); check("R6 two edges new", r, 8'hA0);
    rd(maddr(8'h30), r); check("R5 R6 masked input", r, 8'h20);
    wr(11'h400, 8'hFF);
    rd(maddr(8'hFF), r); check("R4 R6 driven after dir", r, 8'hE0);
    check("R7 out vs input", pin_out, 8'hE0);

    wr(11'h404, 8'h00);
    wr(11'h500, 8'h00);
    wr(11'h3FD, 8'h00);
    check("R8 oe unchanged", pin_oe, 8'hFF);
    check("R8 out unchanged", pin_out, 8'hE0);
    rd(11'h404, r); check("R8 read 404", r, 8'h00);
    rd(11'h7FC, r); check("R8 read 7FC", r, 8'h00);
    rd(11'h3FE, r); check("R8 misaligned read", r, 8'h00);

    report();
  end

endmodule